// File: doc/BRIEF.md
# Trigger and Data Event Alignment Checker

This block pairs the event records that arrive from the timing/trigger receiver with the event headers that are decoded from front-end data links, and checks that both sides describe the same sequence of events. Each record carries an event number and a bunch-crossing number. The trigger side may number its events from a different origin than the data side, so a programmable offset is added to the data event number before the two numbers are compared.

Each side feeds a small queue through a valid/ready interface. Whenever both queues hold an entry, the two heads are compared. A matching pair is retired together. If the trigger head is older than the data head, the data event for it was lost, so the trigger entry is dropped. If the data head is older, it has no trigger, so the data entry is dropped.

Bunch-crossing numbers of matched pairs should be equal. A difference that changes from one pair to the next indicates desynchronization. A data event lost before the first successful match is reported separately from one lost later. The lost-first case typically happens while a link is still acquiring lock.

Back-pressure: `*_ready` is high while the queue on that side has space, and a record is taken on a clock edge where `*_valid` and `*_ready` are both high. A source that cannot stall may ignore `*_ready`. A record offered while the queue is full is discarded, and a sticky overflow flag is set.

Top module: `evt_align_top`

## Requirements
- R1: After reset, all counters are zero, `first_loss`, `desync` and `overflow` are 0, and both `*_ready` outputs are 1.
- R2: `*_ready` is 0 exactly while the queue on that side holds DEPTH (4) entries. A record offered while full is discarded and sets the sticky `overflow` flag, which only reset clears.
- R3: `trig_count` and `data_count` each increment by one for every record accepted on their side, so a stream of N triggers and N-1 data events leaves the two counts different by one.
- R4: A pair matches when trig_eid equals data_eid + `cfg_eid_offset` (modulo 2^24). A matching pair is removed from both queues on the clock edge after both heads are present.
- R5: The trigger head is older when (trig_eid - data_eid - offset), taken as a 24-bit two's complement value, is negative. In that case only the trigger entry is dropped, and both `lost_data_count` and `eid_mismatch_count` increment.
- R6: When that difference is positive, only the data entry is dropped, and `eid_mismatch_count` increments.
- R7: Every matched pair whose bunch-crossing numbers differ increments `bcid_mismatch_count`.
- R8: `desync` is set, and held until reset, in two cases: when a matched pair's bunch-crossing difference (trigger minus data) differs from that of the previous matched pair, or when a trigger entry is dropped after at least one match.
- R9: `first_loss` is set, and held until reset, when a trigger entry is dropped before any pair has matched since reset. Such a drop does not set `desync`.
- R10: The offset is programmable. With an offset of 0, equal event numbers match. With an offset of 1, trigger number k matches data number k-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_eid_offset | input | 24 | Value added to data event number before comparison |
| trig_valid | input | 1 | Trigger record offered |
| trig_ready | output | 1 | Trigger queue has space |
| trig_eid | input | 24 | Trigger event number |
| trig_bcid | input | 12 | Trigger bunch-crossing number |
| data_valid | input | 1 | Data record offered |
| data_ready | output | 1 | Data queue has space |
| data_eid | input | 24 | Data event number |
| data_bcid | input | 12 | Data bunch-crossing number |
| trig_count | output | 32 | Accepted trigger records |
| data_count | output | 32 | Accepted data records |
| eid_mismatch_count | output | 32 | Compared heads with differing event numbers |
| bcid_mismatch_count | output | 32 | Matched pairs with differing bunch-crossing numbers |
| lost_data_count | output | 32 | Trigger entries dropped for lack of data |
| first_loss | output | 1 | Sticky: data lost before the first match |
| desync | output | 1 | Sticky: later loss or changing bunch-crossing difference |
| overflow | output | 1 | Sticky: record offered to a full queue |

## Verification
The side counters and `*_ready` change on the edge that accepts a record. The comparison results (mismatch counters, `lost_data_count`, `first_loss`, `desync`) appear one edge later, because the comparison reads the registered queue heads. A comparison that is blocked behind an older entry resolves one further edge later per entry ahead of it. The bench drives inputs on falling edges, holds each record for a single rising edge, and waits several idle cycles after every scenario before sampling at a falling edge, so every pending comparison has settled. It then checks the outputs against values worked out by hand from the requirements.

// File: rtl/evt_align_pkg.sv
package evt_align_pkg;
  typedef enum logic [1:0] {
    CMP_IDLE      = 2'd0,
    CMP_MATCH     = 2'd1,
    CMP_DROP_TRIG = 2'd2,
    CMP_DROP_DATA = 2'd3
  } cmp_act_e;
endpackage

// File: rtl/evt_align_fifo.sv
module evt_align_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         not_empty,
  output logic         accepted,
  output logic         dropped
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;
  logic          full, do_pop;

  assign full      = (fill == CW'(DEPTH));
  assign in_ready  = !full;
  assign not_empty = (fill != '0);
  assign accepted  = in_valid && !full;
  assign dropped   = in_valid && full;
  assign do_pop    = pop && not_empty;
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accepted) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (accepted) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)   rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({accepted, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // R2: occupancy never exceeds the queue depth
  p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  // R2: an offer to a full queue does not change occupancy unless popped
  p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
endmodule

// File: rtl/evt_align_cmp.sv
module evt_align_cmp
  import evt_align_pkg::*;
#(
  parameter int EID_W  = 24,
  parameter int BCID_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EID_W-1:0]  offset,
  input  logic              t_have,
  input  logic [EID_W-1:0]  t_eid,
  input  logic [BCID_W-1:0] t_bcid,
  input  logic              d_have,
  input  logic [EID_W-1:0]  d_eid,
  input  logic [BCID_W-1:0] d_bcid,
  output logic              t_pop,
  output logic              d_pop,
  output logic [CNT_W-1:0]  eid_mis_cnt,
  output logic [CNT_W-1:0]  bcid_mis_cnt,
  output logic [CNT_W-1:0]  lost_cnt,
  output logic              first_loss,
  output logic              desync
);
  logic [EID_W-1:0]  eid_diff;
  logic [BCID_W-1:0] bc_delta, prev_delta;
  logic              matched_seen;
  cmp_act_e          act;

  assign eid_diff = t_eid - d_eid - offset;
  assign bc_delta = t_bcid - d_bcid;

  always_comb begin
    act = CMP_IDLE;
    if (t_have && d_have) begin
      if (eid_diff == '0)          act = CMP_MATCH;
      else if (eid_diff[EID_W-1])  act = CMP_DROP_TRIG;
      else                         act = CMP_DROP_DATA;
    end
  end

  assign t_pop = (act == CMP_MATCH) || (act == CMP_DROP_TRIG);
  assign d_pop = (act == CMP_MATCH) || (act == CMP_DROP_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eid_mis_cnt  <= '0;
      bcid_mis_cnt <= '0;
      lost_cnt     <= '0;
      first_loss   <= 1'b0;
      desync       <= 1'b0;
      matched_seen <= 1'b0;
      prev_delta   <= '0;
    end else begin
      case (act)
        CMP_MATCH: begin
          matched_seen <= 1'b1;
          prev_delta   <= bc_delta;
          if (bc_delta != '0) bcid_mis_cnt <= bcid_mis_cnt + 1'b1;
          if (matched_seen && (bc_delta != prev_delta)) desync <= 1'b1;
        end
        CMP_DROP_TRIG: begin
          lost_cnt    <= lost_cnt + 1'b1;
          eid_mis_cnt <= eid_mis_cnt + 1'b1;
          if (matched_seen) desync <= 1'b1;
          else              first_loss <= 1'b1;
        end
        CMP_DROP_DATA: eid_mis_cnt <= eid_mis_cnt + 1'b1;
        default: ;
      endcase
    end
  end

  // R5: a trigger-only drop advances the lost and mismatch counters together
  p_trig_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (t_pop && !d_pop) |=> (lost_cnt == $past(lost_cnt) + 1'b1) &&
                          (eid_mis_cnt == $past(eid_mis_cnt) + 1'b1));
  // R6: a data-only drop leaves the lost counter unchanged
  p_data_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (d_pop && !t_pop) |=> $stable(lost_cnt));
  // R9: first_loss is sticky
  p_first_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    first_loss |=> first_loss);
  // R8: desync is sticky
  p_desync_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    desync |=> desync);
endmodule

// File: rtl/evt_align_top.sv
module evt_align_top #(
  parameter int EID_W  = 24,
  parameter int BCID_W = 12,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EID_W-1:0]  cfg_eid_offset,
  input  logic              trig_valid,
  output logic              trig_ready,
  input  logic [EID_W-1:0]  trig_eid,
  input  logic [BCID_W-1:0] trig_bcid,
  input  logic              data_valid,
  output logic              data_ready,
  input  logic [EID_W-1:0]  data_eid,
  input  logic [BCID_W-1:0] data_bcid,
  output logic [CNT_W-1:0]  trig_count,
  output logic [CNT_W-1:0]  data_count,
  output logic [CNT_W-1:0]  eid_mismatch_count,
  output logic [CNT_W-1:0]  bcid_mismatch_count,
  output logic [CNT_W-1:0]  lost_data_count,
  output logic              first_loss,
  output logic              desync,
  output logic              overflow
);
  localparam int RW = EID_W + BCID_W;
  localparam int NS = 2;  // side 0 = trigger, side 1 = data

  logic [RW-1:0]    rec_in [NS];
  logic [RW-1:0]    rec_hd [NS];
  logic [NS-1:0]    v_in, rdy, pop, have, acc, drp;
  logic [CNT_W-1:0] side_cnt [NS];

  assign rec_in[0] = {trig_eid, trig_bcid};
  assign rec_in[1] = {data_eid, data_bcid};
  assign v_in      = {data_valid, trig_valid};
  assign trig_ready = rdy[0];
  assign data_ready = rdy[1];

  for (genvar s = 0; s < NS; s++) begin : g_side
    evt_align_fifo #(.W(RW), .DEPTH(DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n),
      .in_valid(v_in[s]), .in_ready(rdy[s]), .in_data(rec_in[s]),
      .pop(pop[s]), .head(rec_hd[s]), .not_empty(have[s]),
      .accepted(acc[s]), .dropped(drp[s])
    );
    always_ff @(posedge clk) begin
      if (!rst_n)      side_cnt[s] <= '0;
      else if (acc[s]) side_cnt[s] <= side_cnt[s] + 1'b1;
    end
  end

  assign trig_count = side_cnt[0];
  assign data_count = side_cnt[1];

  always_ff @(posedge clk) begin
    if (!rst_n)        overflow <= 1'b0;
    else if (|drp)     overflow <= 1'b1;
  end

  evt_align_cmp #(.EID_W(EID_W), .BCID_W(BCID_W), .CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .offset(cfg_eid_offset),
    .t_have(have[0]), .t_eid(rec_hd[0][RW-1:BCID_W]), .t_bcid(rec_hd[0][BCID_W-1:0]),
    .d_have(have[1]), .d_eid(rec_hd[1][RW-1:BCID_W]), .d_bcid(rec_hd[1][BCID_W-1:0]),
    .t_pop(pop[0]), .d_pop(pop[1]),
    .eid_mis_cnt(eid_mismatch_count), .bcid_mis_cnt(bcid_mismatch_count),
    .lost_cnt(lost_data_count), .first_loss(first_loss), .desync(desync)
  );

  // R3: the trigger count advances by at most one per cycle
  p_trig_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |=> (trig_count - $past(trig_count)) <= 1);
  // R2: overflow stays set once raised
  p_ovf_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R2: an offer refused for lack of space raises overflow
  p_ovf_on_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && !trig_ready) |=> overflow);
endmodule

// File: tb/evt_align_top_tb_top.sv
module evt_align_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] cfg_eid_offset = '0;
  logic        trig_valid = 1'b0, data_valid = 1'b0;
  logic [23:0] trig_eid = '0, data_eid = '0;
  logic [11:0] trig_bcid = '0, data_bcid = '0;
  logic        trig_ready, data_ready, first_loss, desync, overflow;
  logic [31:0] trig_count, data_count, eid_mismatch_count, bcid_mismatch_count, lost_data_count;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_align_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_eid_offset(cfg_eid_offset),
    .trig_valid(trig_valid), .trig_ready(trig_ready), .trig_eid(trig_eid), .trig_bcid(trig_bcid),
    .data_valid(data_valid), .data_ready(data_ready), .data_eid(data_eid), .data_bcid(data_bcid),
    .trig_count(trig_count), .data_count(data_count),
    .eid_mismatch_count(eid_mismatch_count), .bcid_mismatch_count(bcid_mismatch_count),
    .lost_data_count(lost_data_count), .first_loss(first_loss), .desync(desync),
    .overflow(overflow)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [23:0] off);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_eid_offset = off;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_trig(input logic [23:0] e, input logic [11:0] b);
    @(negedge clk);
    trig_valid = 1'b1; trig_eid = e; trig_bcid = b;
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  task automatic send_data(input logic [23:0] e, input logic [11:0] b);
    @(negedge clk);
    data_valid = 1'b1; data_eid = e; data_bcid = b;
    @(negedge clk);
    data_valid = 1'b0;
  endtask

  task automatic send_pair(input logic [23:0] te, input logic [23:0] de,
                           input logic [11:0] tb, input logic [11:0] db);
    @(negedge clk);
    trig_valid = 1'b1; trig_eid = te; trig_bcid = tb;
    data_valid = 1'b1; data_eid = de; data_bcid = db;
    @(negedge clk);
    trig_valid = 1'b0; data_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(24'd1);
    idle(1);
    check("R1 trig_count", trig_count, 0);
    check("R1 data_count", data_count, 0);
    check("R1 eid_mis", eid_mismatch_count, 0);
    check("R1 flags", {29'd0, first_loss, desync, overflow}, 0);
    check("R1 ready", {30'd0, trig_ready, data_ready}, 3);
  endtask

  task automatic t_offset_match();
    do_reset(24'd1);
    for (int i = 0; i < 4; i++) send_pair(24'(i + 1), 24'(i), 12'(10 + i), 12'(10 + i));
    idle(6);
    check("R3 trig_count", trig_count, 4);
    check("R3 data_count", data_count, 4);
    check("R10 eid_mis offset1", eid_mismatch_count, 0);
    check("R4 lost", lost_data_count, 0);
    check("R7 bcid_mis none", bcid_mismatch_count, 0);
    check("R8 desync clear", desync, 0);
  endtask

  task automatic t_bcid_drift();
    do_reset(24'd0);
    for (int i = 0; i < 3; i++) send_pair(24'(i), 24'(i), 12'(23 + i), 12'(20 + i));
    idle(6);
    check("R7 bcid_mis const", bcid_mismatch_count, 3);
    check("R8 constant delta no desync", desync, 0);
    send_pair(24'd3, 24'd3, 12'd50, 12'd45);
    idle(6);
    check("R7 bcid_mis", bcid_mismatch_count, 4);
    check("R8 delta change desync", desync, 1);
  endtask

  task automatic t_first_loss();
    do_reset(24'd1);
    send_trig(24'd1, 12'd5);
    send_trig(24'd2, 12'd6);
    send_trig(24'd3, 12'd7);
    send_data(24'd1, 12'd6);
    send_data(24'd2, 12'd7);
    idle(6);
    check("R5 lost first", lost_data_count, 1);
    check("R5 eid_mis first", eid_mismatch_count, 1);
    check("R9 first_loss", first_loss, 1);
    check("R9 no desync", desync, 0);
    check("R3 trig vs data", trig_count - data_count, 1);
    send_trig(24'd4, 12'd8);
    send_trig(24'd5, 12'd9);
    send_data(24'd4, 12'd9);
    idle(6);
    check("R5 lost later", lost_data_count, 2);
    check("R8 later loss desync", desync, 1);
    check("R9 still set", first_loss, 1);
    check("R7 bcid ok", bcid_mismatch_count, 0);
  endtask

  task automatic t_extra_data();
    do_reset(24'd1);
    send_trig(24'd6, 12'd1);
    send_data(24'd4, 12'd0);
    idle(4);
    check("R6 eid_mis", eid_mismatch_count, 1);
    check("R6 lost untouched", lost_data_count, 0);
    send_data(24'd5, 12'd1);
    idle(6);
    check("R6 then match", eid_mismatch_count, 1);
    check("R6 trig ready", trig_ready, 1);
    check("R6 flags", {first_loss, desync}, 0);
  endtask

  task automatic t_n_vs_n1();
    do_reset(24'd0);
    send_pair(24'd7, 24'd7, 12'd0, 12'd0);
    send_pair(24'd8, 24'd8, 12'd1, 12'd1);
    send_trig(24'd9, 12'd2);
    idle(6);
    check("R3 trig N", trig_count, 3);
    check("R3 data N-1", data_count, 2);
    check("R10 offset0 eid_mis", eid_mismatch_count, 0);
  endtask

  task automatic t_overflow();
    do_reset(24'd1);
    for (int i = 0; i < 4; i++) send_trig(24'(i + 1), 12'd0);
    check("R2 ready low full", trig_ready, 0);
    check("R2 no ovf yet", overflow, 0);
    send_trig(24'd5, 12'd0);
    idle(2);
    check("R2 overflow", overflow, 1);
    check("R2 count capped", trig_count, 4);
    send_data(24'd0, 12'd0);
    idle(4);
    check("R2 ready back", trig_ready, 1);
    check("R2 overflow sticky", overflow, 1);
    check("R4 pair retired", eid_mismatch_count, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_offset_match();
    t_bcid_drift();
    t_first_loss();
    t_extra_data();
    t_n_vs_n1();
    t_overflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule